// File: doc/BRIEF.md
# Host Bus Wait-State Strobe Controller

This block runs single accesses on a 16-bit external host bus. A request on the internal side carries an address, write data, byte enables and a direction flag. The block drives the address and asserts a chip select for a fixed two-clock address phase. It then asserts the matching active-low strobe for a data phase. The data phase is two clocks long, plus two clocks for each configured wait state. Reads and writes take their wait-state count from separate 2-bit settings. After the strobe rises, a read returns the bus value that was sampled at that edge, and every access ends with a one-clock done pulse.

Two chip-select lines are provided. In the split modes, one address bit chooses between them. Both selects use the same wait-state settings. Two active-low byte-select lines allow 8-bit transfers when byte selects are enabled. When they are disabled, every transfer is a full 16-bit word. The configuration inputs are captured when a request is accepted, so they can change at any time without disturbing an access that is already running.

Top module: `hbus_strobe_ctrl`

## Requirements
- R1: While reset is asserted and after it, until a request arrives, bus_rd_n, bus_wr_n, both bus_cs_n bits and both bus_bsel_n bits are 1, bus_doe is 0 and rsp_done is 0.
- R2: A request is accepted only when the block is idle. It is not accepted during an access or in the done cycle. Such a request is ignored, and the block does not record it. The request fields and all configuration inputs are captured at the accepting edge. Later changes to them do not affect the running access.
- R3: The address phase begins at the clock edge that accepts the request. It lasts exactly 2 clocks, whatever the wait settings are. bus_addr holds the captured address through the address phase and the data phase.
- R4: The data phase immediately follows the address phase and lasts 2 + 2*N clocks. N is cfg_rd_ws for a read and cfg_wr_ws for a write, each from 0 to 3. The strobe is low for the whole data phase and at no other time.
- R5: A read pulls only bus_rd_n low and a write pulls only bus_wr_n low. The two strobes are never low together.
- R6: With cfg_cs_mode equal to 2 or 3, address bit 15 selects the chip select: 0 selects bus_cs_n[0] and 1 selects bus_cs_n[1]. With mode 0 or 1, only bus_cs_n[0] is used. The selected line is low during the address and data phases and high otherwise. Both selects use the same wait-state counts.
- R7: When cfg_bsel_en is 1, bus_bsel_n[i] is low during the strobe exactly when req_be[i] is 1. Bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. When cfg_bsel_en is 0, both lines are low during the strobe. Outside the strobe, both lines are high.
- R8: For a write, bus_doe is 1 during the data phase only, and bus_dout carries the captured write data.
- R9: rsp_done is high for exactly the one clock that follows the rising edge of the strobe. For a read, rsp_rdata equals bus_din as sampled at the edge that ends the data phase, and it holds that value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_rdata | output | 16 | Last read data |
| rsp_done | output | 1 | One-clock completion pulse |
| cfg_rd_ws | input | 2 | Read wait states |
| cfg_wr_ws | input | 2 | Write wait states |
| cfg_cs_mode | input | 2 | Chip-select mode (2/3 = split on address bit 15) |
| cfg_bsel_en | input | 1 | Byte-select enable |
| bus_addr | output | 16 | External address |
| bus_dout | output | 16 | External write data |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | 16 | External read data |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_cs_n | output | 2 | Active-low chip selects |
| bus_bsel_n | output | 2 | Active-low byte selects |

## Verification
A request held at an edge starts the address phase on the next clock. The strobe falls 2 clocks after that edge. It rises 2 + 2*N clocks later, and rsp_done and the read data appear in the clock right after the strobe rises. The bench keeps a behavioural model that counts the clocks since each acceptance and advances on the same rising edge as the design. Every output is compared on the falling edge, so each expected value is checked in the one clock it is due and never in a neighbouring clock. The stimulus changes configuration, holds requests during busy and done cycles, and resets in the middle of an access.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

   localparam int CS_MODE_W = 2;
   localparam int CS_LINES  = 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2,
      ST_DONE = 2'd3
   } hb_state_e;

   function automatic logic split_cs(input logic [CS_MODE_W-1:0] mode);
      return (mode == 2'd2) || (mode == 2'd3);
   endfunction

endpackage

// File: rtl/hbus_phase_timer.sv
module hbus_phase_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/hbus_select_decode.sv
module hbus_select_decode
   import hbus_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int CS_SEL_BIT = 15,
   parameter int BE_W       = 2,
   parameter bit HAS_BSEL   = 1'b1
) (
   input  logic                 active,
   input  logic                 strobe,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [CS_MODE_W-1:0] cs_mode,
   input  logic                 bsel_en,
   input  logic [BE_W-1:0]      be,
   output logic [CS_LINES-1:0]  cs_n,
   output logic [BE_W-1:0]      bsel_n
);

   logic use_cs1;

   assign use_cs1 = split_cs(cs_mode) && addr[CS_SEL_BIT];

   always_comb begin
      cs_n = '1;
      if (active)
         cs_n[use_cs1] = 1'b0;
   end

   generate
      if (HAS_BSEL) begin : g_bsel
         always_comb begin
            if (!strobe)
               bsel_n = '1;
            else if (bsel_en)
               bsel_n = ~be;
            else
               bsel_n = '0;
         end
      end else begin : g_word_only
         assign bsel_n = strobe ? '0 : '1;
      end
   endgenerate

endmodule

// File: rtl/hbus_strobe_ctrl.sv
module hbus_strobe_ctrl
   import hbus_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 16,
   parameter int WS_W           = 2,
   parameter int ADDR_CLKS      = 2,
   parameter int DATA_BASE_CLKS = 2,
   parameter int CLKS_PER_WS    = 2,
   parameter int CS_SEL_BIT     = 15,
   parameter bit HAS_BSEL       = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic [DATA_W/8-1:0]  req_be,
   output logic [DATA_W-1:0]    rsp_rdata,
   output logic                 rsp_done,
   input  logic [WS_W-1:0]      cfg_rd_ws,
   input  logic [WS_W-1:0]      cfg_wr_ws,
   input  logic [1:0]           cfg_cs_mode,
   input  logic                 cfg_bsel_en,
   output logic [ADDR_W-1:0]    bus_addr,
   output logic [DATA_W-1:0]    bus_dout,
   output logic                 bus_doe,
   input  logic [DATA_W-1:0]    bus_din,
   output logic                 bus_rd_n,
   output logic                 bus_wr_n,
   output logic [1:0]           bus_cs_n,
   output logic [DATA_W/8-1:0]  bus_bsel_n
);

   localparam int BE_W     = DATA_W / 8;
   localparam int MAX_WS   = (1 << WS_W) - 1;
   localparam int MAX_DATA = DATA_BASE_CLKS + CLKS_PER_WS * MAX_WS;
   localparam int MAX_PH   = (MAX_DATA > ADDR_CLKS) ? MAX_DATA : ADDR_CLKS;
   localparam int CNT_W    = $clog2(MAX_PH + 1);

   initial begin
      assert (DATA_W % 8 == 0) else $error("DATA_W must be whole bytes");
      assert (CS_SEL_BIT < ADDR_W) else $error("CS_SEL_BIT outside address");
      assert (ADDR_CLKS >= 1 && DATA_BASE_CLKS >= 1) else $error("phases need a clock");
      assert (CS_MODE_W == 2) else $error("chip-select mode width");
   end

   hb_state_e              state_q;
   logic [ADDR_W-1:0]      addr_q;
   logic [DATA_W-1:0]      wdata_q;
   logic [DATA_W-1:0]      rdata_q;
   logic [BE_W-1:0]        be_q;
   logic                   wr_q;
   logic [1:0]             mode_q;
   logic                   bsel_q;
   logic [WS_W-1:0]        ws_q;

   logic                   accept;
   logic                   ph_expired;
   logic                   tmr_load;
   logic [CNT_W-1:0]       tmr_val;
   logic [CNT_W-1:0]       data_len;
   logic                   strobe;
   logic                   active;

   assign accept   = (state_q == ST_IDLE) && req_valid;
   assign data_len = CNT_W'(DATA_BASE_CLKS) + CNT_W'(CLKS_PER_WS) * CNT_W'(ws_q);
   assign tmr_load = accept || ((state_q == ST_ADDR) && ph_expired);
   assign tmr_val  = accept ? CNT_W'(ADDR_CLKS - 1) : (data_len - 1'b1);

   hbus_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (ph_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         be_q    <= '0;
         wr_q    <= 1'b0;
         mode_q  <= '0;
         bsel_q  <= 1'b0;
         ws_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_ADDR;
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
               be_q    <= req_be;
               wr_q    <= req_write;
               mode_q  <= cfg_cs_mode;
               bsel_q  <= cfg_bsel_en;
               ws_q    <= req_write ? cfg_wr_ws : cfg_rd_ws;
            end
            ST_ADDR: if (ph_expired) state_q <= ST_DATA;
            ST_DATA: if (ph_expired) begin
               state_q <= ST_DONE;
               if (!wr_q) rdata_q <= bus_din;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign strobe    = (state_q == ST_DATA);
   assign active    = (state_q == ST_ADDR) || strobe;
   assign bus_addr  = addr_q;
   assign bus_dout  = wdata_q;
   assign bus_doe   = strobe && wr_q;
   assign bus_rd_n  = !(strobe && !wr_q);
   assign bus_wr_n  = !(strobe && wr_q);
   assign rsp_done  = (state_q == ST_DONE);
   assign rsp_rdata = rdata_q;

   hbus_select_decode #(
      .ADDR_W     (ADDR_W),
      .CS_SEL_BIT (CS_SEL_BIT),
      .BE_W       (BE_W),
      .HAS_BSEL   (HAS_BSEL)
   ) u_decode (
      .active  (active),
      .strobe  (strobe),
      .addr    (addr_q),
      .cs_mode (mode_q),
      .bsel_en (bsel_q),
      .be      (be_q),
      .cs_n    (bus_cs_n),
      .bsel_n  (bus_bsel_n)
   );

   // Length of the current strobe pulse, kept for the checks below.
   logic [CNT_W:0] strb_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         strb_run <= '0;
      else if (!bus_rd_n || !bus_wr_n)
         strb_run <= strb_run + 1'b1;
      else
         strb_run <= '0;
   end

   a_r4_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> (strb_run == {1'b0, data_len}));

   a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_wr_n));

   a_r6_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~bus_cs_n));

   a_r6_strobe_has_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n || !bus_wr_n) |-> (bus_cs_n != 2'b11));

   a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_cs_n != 2'b11) && $past(bus_cs_n != 2'b11)) |-> $stable(bus_addr));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> $past(!bus_rd_n || !bus_wr_n));

endmodule

// File: tb/hbus_strobe_ctrl_tb.sv
module hbus_strobe_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic [15:0] rsp_rdata;
   logic        rsp_done;
   logic [1:0]  cfg_rd_ws = '0;
   logic [1:0]  cfg_wr_ws = '0;
   logic [1:0]  cfg_cs_mode = '0;
   logic        cfg_bsel_en = 1'b0;
   logic [15:0] bus_addr;
   logic [15:0] bus_dout;
   logic        bus_doe;
   logic [15:0] bus_din = '0;
   logic        bus_rd_n;
   logic        bus_wr_n;
   logic [1:0]  bus_cs_n;
   logic [1:0]  bus_bsel_n;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   bit started = 1'b0;

   always #2.5 clk = ~clk;

   hbus_strobe_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
      .cfg_rd_ws(cfg_rd_ws), .cfg_wr_ws(cfg_wr_ws), .cfg_cs_mode(cfg_cs_mode),
      .cfg_bsel_en(cfg_bsel_en), .bus_addr(bus_addr), .bus_dout(bus_dout),
      .bus_doe(bus_doe), .bus_din(bus_din), .bus_rd_n(bus_rd_n),
      .bus_wr_n(bus_wr_n), .bus_cs_n(bus_cs_n), .bus_bsel_n(bus_bsel_n)
   );

   // Behavioural reference: clocks elapsed since acceptance.
   bit          m_busy = 0, m_done = 0, m_wr = 0, m_bsel = 0;
   int          m_t = 0, m_len = 0;
   logic [15:0] m_addr = '0, m_wdata = '0, m_rdata = '0;
   logic [1:0]  m_be = '0, m_mode = '0;

   always @(posedge clk) begin
      cyc++;
      started = 1'b1;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_rdata = '0;
      end else if (m_done) begin
         m_done = 0;
      end else if (m_busy) begin
         if (m_t == 1 + m_len) begin
            m_busy = 0; m_done = 1;
            if (!m_wr) m_rdata = bus_din;
         end else m_t++;
      end else if (req_valid) begin
         m_busy = 1; m_t = 0; m_wr = req_write; m_addr = req_addr;
         m_wdata = req_wdata; m_be = req_be; m_mode = cfg_cs_mode;
         m_bsel = cfg_bsel_en;
         m_len = 2 + 2 * int'(req_write ? cfg_wr_ws : cfg_rd_ws);
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      bus_din <= 16'(cyc * 16'h1357 + 16'h0f0f);
      if (started) begin
         bit data_ph;
         logic [1:0] e_cs, e_bs;
         data_ph = m_busy && (m_t >= 2);
         e_cs = 2'b11;
         if (m_busy) e_cs[(m_mode >= 2'd2) && m_addr[15]] = 1'b0;
         e_bs = !data_ph ? 2'b11 : (m_bsel ? ~m_be : 2'b00);
         chk("R4/R5 bus_rd_n", 32'(bus_rd_n), 32'(!(data_ph && !m_wr)));
         chk("R4/R5 bus_wr_n", 32'(bus_wr_n), 32'(!(data_ph && m_wr)));
         chk("R6 bus_cs_n", 32'(bus_cs_n), 32'(e_cs));
         chk("R7 bus_bsel_n", 32'(bus_bsel_n), 32'(e_bs));
         chk("R8 bus_doe", 32'(bus_doe), 32'(data_ph && m_wr));
         chk("R9 rsp_done", 32'(rsp_done), 32'(m_done));
         if (m_busy) chk("R3 bus_addr", 32'(bus_addr), 32'(m_addr));
         if (data_ph && m_wr) chk("R8 bus_dout", 32'(bus_dout), 32'(m_wdata));
         if (m_done && !m_wr) chk("R9 rsp_rdata", 32'(rsp_rdata), 32'(m_rdata));
      end
   end

   task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] be, input logic [1:0] rws, input logic [1:0] wws,
                         input logic [1:0] mode, input bit bsel);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      cfg_rd_ws = rws; cfg_wr_ws = wws; cfg_cs_mode = mode; cfg_bsel_en = bsel;
      @(negedge clk);
      req_valid = 0;
      while (m_busy || m_done) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: idle outputs under reset
      chk("R1 reset rd/wr", 32'({bus_rd_n, bus_wr_n}), 32'h3);
      chk("R1 reset cs/bsel", 32'({bus_cs_n, bus_bsel_n}), 32'hf);
      chk("R1 reset done/doe", 32'({rsp_done, bus_doe}), 32'h0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk("R1 idle after reset", 32'({bus_rd_n, bus_wr_n, bus_cs_n}), 32'hf);
      // R4: reads and writes across every wait count
      for (int w = 0; w < 4; w++) access(0, 16'h0100 + 16'(w), '0, 2'b11, 2'(w), 2'(3 - w), 0, 0);
      for (int w = 0; w < 4; w++) access(1, 16'h0200 + 16'(w), 16'hbe00 + 16'(w), 2'b11, 2'(3 - w), 2'(w), 0, 0);
      // R6: chip-select modes and address bit 15
      for (int m = 0; m < 4; m++) begin
         access(0, 16'h8abc, '0, 2'b11, 2'd1, 2'd0, 2'(m), 0);
         access(1, 16'h0abc, 16'h5a5a, 2'b11, 2'd0, 2'd2, 2'(m), 0);
         access(1, 16'hf00f, 16'h1234, 2'b11, 2'd0, 2'd1, 2'(m), 0);
      end
      // R7: byte selects enabled and disabled
      for (int b = 1; b < 4; b++) begin
         access(1, 16'h4000, 16'hc3c3, 2'(b), 2'd0, 2'd1, 2'd0, 1);
         access(0, 16'h4002, '0, 2'(b), 2'd2, 2'd0, 2'd3, 1);
         access(1, 16'h4004, 16'h3c3c, 2'(b), 2'd0, 2'd0, 2'd0, 0);
      end
      // R2: configuration changed after acceptance is not used
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = 16'h8001; req_be = 2'b01;
      cfg_rd_ws = 0; cfg_cs_mode = 2; cfg_bsel_en = 1;
      @(negedge clk);
      req_valid = 0; cfg_rd_ws = 3; cfg_cs_mode = 0; cfg_bsel_en = 0; req_addr = 16'h0000;
      while (m_busy || m_done) @(negedge clk);
      // R2: request held through busy and done cycles, fields changing
      for (int k = 0; k < 80; k++) begin
         req_valid = 1; req_write = k[2]; req_addr = 16'(k * 16'h0731);
         req_wdata = 16'(k * 16'h0123); req_be = 2'(k); cfg_rd_ws = 2'(k);
         cfg_wr_ws = 2'(k >> 1); cfg_cs_mode = 2'(k >> 2); cfg_bsel_en = k[0];
         @(negedge clk);
      end
      req_valid = 0;
      while (m_busy || m_done) @(negedge clk);
      // R1: reset in the middle of an access
      @(negedge clk);
      req_valid = 1; req_write = 1; cfg_wr_ws = 3;
      @(negedge clk);
      req_valid = 0;
      repeat (3) @(negedge clk);
      rst_n = 0;
      #1;
      chk("R1 async reset strobes", 32'({bus_rd_n, bus_wr_n, bus_cs_n, bus_bsel_n}), 32'h3f);
      @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
      access(0, 16'h8123, '0, 2'b10, 2'd3, 2'd0, 2'd2, 1);
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule